// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns one configuration-space request into a single host-bus cycle. A request holds a bus number, a device/function byte, a byte offset, an access size, a direction and write data. The block decides whether the target sits on the local bus or behind a bridge. It then builds the matching configuration address and places that address in a sparse host window. The window address also carries the access size. Write data is moved onto the byte lanes the offset selects. Read data coming back is moved down to bit 0.

For bridged (Type 1) accesses, the bus-cycle-type field in an external address-extension register must say "Type 1" while the cycle runs. The block captures the register's value when it accepts the request. It writes the field before the cycle and writes the captured value back after the cycle. A request the block cannot serve gets a response with an error status and no bus cycle: either an unsupported size or a local device number above the selectable range.

Requests arrive through a valid/ready handshake, and only one is in flight at a time. The host side is a simple valid/done pair. The response is a one-cycle pulse carrying the status and the data.

Top module: `cfg_addr_gen`

## Requirements
- R1: Bus number 0 selects a Type 0 cycle, whose configuration address ends in bits 1:0 = 00. Any other bus number selects a Type 1 cycle, ending in 01. The device number is devfn[7:3] and the function number is devfn[2:0].
- R2: A Type 0 request whose device number is greater than 20 completes with status 01 (not found). It issues no host cycle and makes no extension-register write.
- R3: The Type 0 configuration address has one set bit at position 11 + device. The function sits in bits 10:8 and offset[7:2] in bits 7:2. All other bits are zero.
- R4: The Type 1 configuration address carries the bus in bits 23:16, the device in 15:11, the function in 10:8, offset[7:2] in 7:2 and 01 in 1:0. Bits 31:24 are zero.
- R5: host_addr equals (configuration address << 5) + (size-1)*8 + CFG_BASE. The size field is 0, 8 or 24 for sizes 1, 2 and 4.
- R6: For a write, host_wdata equals req_wdata shifted left by 8*offset[1:0].
- R7: For a successful read, rsp_data equals host_rdata shifted right by 8*offset[1:0]. Writes and failed requests return rsp_data = 0.
- R8: During a Type 1 host cycle, extension-register bits 31:30 hold 01 and bits 29:0 keep the value captured at acceptance. A Type 0 request writes nothing to the register.
- R9: After a Type 1 cycle, and before the response, the register is written back with exactly the value captured at acceptance.
- R10: A size other than 1, 2 or 4 completes with status 10, no host cycle and no register write. This check takes precedence over R2. Status 00 means success.
- R11: req_ready is high only when idle and drops right after an accept. host_valid, host_addr and host_wdata stay stable until host_done is seen.
- R12: rsp_valid is a one-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device (7:3) and function (2:0) |
| req_offset | input | 8 | Byte offset in configuration space |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 00 ok, 01 not found, 10 bad size |
| rsp_data | output | 32 | Right-aligned read data |
| host_valid | output | 1 | Host cycle requested |
| host_write | output | 1 | Host cycle direction |
| host_addr | output | ADDR_W | Sparse host address |
| host_wdata | output | 32 | Lane-aligned write data |
| host_done | input | 1 | Host cycle complete |
| host_rdata | input | 32 | Host read data, valid with host_done |
| ext_value | input | 32 | Current extension-register value |
| ext_we | output | 1 | Extension-register write strobe |
| ext_wdata | output | 32 | Extension-register write value |

## Verification
A corrupted request register or decode shows up at the ports within a few cycles. It appears as a wrong host_addr on the first cycle host_valid is high, or as a response with the wrong status and an unexpected host cycle. A lost copy of the captured extension value shows up in two places. The first is the register value seen while host_valid is high. The second is the value written back just before rsp_valid, so one Type 1 request exposes it. A sequencer stuck in the wrong state shows up as req_ready failing to drop or return, or as rsp_valid lasting more than one cycle.

// File: rtl/cfg_addr_pkg.sv
package cfg_addr_pkg;

   localparam int BUS_W   = 8;
   localparam int DEVFN_W = 8;
   localparam int OFS_W   = 8;
   localparam int SIZE_W  = 3;
   localparam int DATA_W  = 32;
   localparam int CFG_W   = 32;
   localparam int EXT_W   = 32;

   typedef enum logic [1:0] {
      CFG_OK      = 2'b00,
      CFG_NODEV   = 2'b01,
      CFG_BADSIZE = 2'b10
   } cfg_status_e;

   typedef enum logic [2:0] {
      SQ_IDLE    = 3'd0,
      SQ_CHECK   = 3'd1,
      SQ_EXT_SET = 3'd2,
      SQ_ISSUE   = 3'd3,
      SQ_EXT_RST = 3'd4,
      SQ_RESP    = 3'd5
   } seq_state_e;

   typedef struct packed {
      logic [BUS_W-1:0]   bus;
      logic [DEVFN_W-1:0] devfn;
      logic [OFS_W-1:0]   ofs;
      logic [SIZE_W-1:0]  size;
      logic               write;
      logic [DATA_W-1:0]  wdata;
   } cfg_req_t;

endpackage

// File: rtl/cfg_addr_encode.sv
module cfg_addr_encode
   import cfg_addr_pkg::*;
#(
   parameter int                ADDR_W       = 40,
   parameter logic [ADDR_W-1:0] CFG_BASE     = 40'hC0_0000_0000,
   parameter int                MAX_T0_DEV   = 20,
   parameter int                IDSEL_LSB    = 11,
   parameter int                SPARSE_SHIFT = 5
)(
   input  logic [BUS_W-1:0]   bus_i,
   input  logic [DEVFN_W-1:0] devfn_i,
   input  logic [OFS_W-1:0]   ofs_i,
   input  logic [SIZE_W-1:0]  size_i,
   output logic               type1_o,
   output cfg_status_e        status_o,
   output logic [ADDR_W-1:0]  host_addr_o
);

   localparam int N_IDSEL = MAX_T0_DEV + 1;
   localparam int DEV_W   = 5;
   localparam int FN_W    = 3;
   localparam int REG_W   = 6;

   if (MAX_T0_DEV > 31) begin : g_bad_dev
      $error("MAX_T0_DEV exceeds the device field range");
   end
   if (IDSEL_LSB + MAX_T0_DEV > CFG_W - 1) begin : g_bad_idsel
      $error("select bit would fall outside the configuration address");
   end
   if (SPARSE_SHIFT < 5) begin : g_bad_shift
      $error("sparse shift too small to hold the size field");
   end
   if (ADDR_W < CFG_W + SPARSE_SHIFT) begin : g_bad_addr
      $error("host address too narrow for the shifted configuration address");
   end

   logic [DEV_W-1:0]    dev;
   logic [FN_W-1:0]     fn;
   logic [REG_W-1:0]    regno;
   logic [N_IDSEL-1:0]  idsel_hot;
   logic                dev_ok;
   logic [CFG_W-1:0]    idsel_field;
   logic [CFG_W-1:0]    cfg_t0;
   logic [CFG_W-1:0]    cfg_t1;
   logic [CFG_W-1:0]    cfg_addr;
   logic                size_ok;
   logic [SPARSE_SHIFT-1:0] size_field;

   assign dev   = devfn_i[DEVFN_W-1 -: DEV_W];
   assign fn    = devfn_i[FN_W-1:0];
   assign regno = ofs_i[OFS_W-1:2];

   for (genvar g = 0; g < N_IDSEL; g++) begin : g_idsel
      assign idsel_hot[g] = (dev == DEV_W'(g));
   end

   assign dev_ok      = |idsel_hot;
   assign idsel_field = CFG_W'(idsel_hot) << IDSEL_LSB;
   assign cfg_t0      = idsel_field | CFG_W'({fn, regno, 2'b00});
   assign cfg_t1      = CFG_W'({bus_i, dev, fn, regno, 2'b01});

   assign type1_o  = (bus_i != '0);
   assign cfg_addr = type1_o ? cfg_t1 : cfg_t0;

   always_comb begin
      size_ok    = 1'b1;
      size_field = '0;
      case (size_i)
         3'd1:    size_field = SPARSE_SHIFT'(0);
         3'd2:    size_field = SPARSE_SHIFT'(8);
         3'd4:    size_field = SPARSE_SHIFT'(24);
         default: size_ok    = 1'b0;
      endcase
   end

   always_comb begin
      if (!size_ok)
         status_o = CFG_BADSIZE;
      else if (!type1_o && !dev_ok)
         status_o = CFG_NODEV;
      else
         status_o = CFG_OK;
   end

   assign host_addr_o = (ADDR_W'(cfg_addr) << SPARSE_SHIFT)
                      + ADDR_W'(size_field) + CFG_BASE;

endmodule

// File: rtl/cfg_lane_shift.sv
module cfg_lane_shift #(
   parameter int DATA_W  = 32,
   parameter bit TO_HIGH = 1'b1,
   parameter int LANE_W  = $clog2(DATA_W / 8)
)(
   input  logic [DATA_W-1:0] data_i,
   input  logic [LANE_W-1:0] lane_i,
   output logic [DATA_W-1:0] data_o
);

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("data width must be a multiple of 8 and at least 16");
   end

   logic [LANE_W+2:0] bit_shift;
   assign bit_shift = {lane_i, 3'b000};

   if (TO_HIGH) begin : g_up
      assign data_o = data_i << bit_shift;
   end else begin : g_down
      assign data_o = data_i >> bit_shift;
   end

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
   import cfg_addr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid_i,
   input  logic        host_done_i,
   input  cfg_status_e status_i,
   input  logic        type1_i,
   output logic        req_ready_o,
   output logic        accept_o,
   output logic        check_o,
   output logic        host_valid_o,
   output logic        ext_set_o,
   output logic        ext_rst_o,
   output logic        rd_capture_o,
   output logic        rsp_valid_o
);

   seq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SQ_IDLE:
            if (req_valid_i) state_d = SQ_CHECK;
         SQ_CHECK:
            if (status_i != CFG_OK) state_d = SQ_RESP;
            else if (type1_i)       state_d = SQ_EXT_SET;
            else                    state_d = SQ_ISSUE;
         SQ_EXT_SET:
            state_d = SQ_ISSUE;
         SQ_ISSUE:
            if (host_done_i) state_d = type1_i ? SQ_EXT_RST : SQ_RESP;
         SQ_EXT_RST:
            state_d = SQ_RESP;
         SQ_RESP:
            state_d = SQ_IDLE;
         default:
            state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_IDLE;
      else        state_q <= state_d;
   end

   assign req_ready_o  = (state_q == SQ_IDLE);
   assign accept_o     = req_ready_o && req_valid_i;
   assign check_o      = (state_q == SQ_CHECK);
   assign host_valid_o = (state_q == SQ_ISSUE);
   assign ext_set_o    = (state_q == SQ_EXT_SET);
   assign ext_rst_o    = (state_q == SQ_EXT_RST);
   assign rd_capture_o = host_valid_o && host_done_i;
   assign rsp_valid_o  = (state_q == SQ_RESP);

endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
   import cfg_addr_pkg::*;
#(
   parameter int                ADDR_W       = 40,
   parameter logic [ADDR_W-1:0] CFG_BASE     = 40'hC0_0000_0000,
   parameter int                MAX_T0_DEV   = 20,
   parameter int                IDSEL_LSB    = 11,
   parameter int                SPARSE_SHIFT = 5,
   parameter int                TYPE_MSB     = 31
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [7:0]        req_bus,
   input  logic [7:0]        req_devfn,
   input  logic [7:0]        req_offset,
   input  logic [2:0]        req_size,
   input  logic              req_write,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [1:0]        rsp_status,
   output logic [31:0]       rsp_data,
   output logic              host_valid,
   output logic              host_write,
   output logic [ADDR_W-1:0] host_addr,
   output logic [31:0]       host_wdata,
   input  logic              host_done,
   input  logic [31:0]       host_rdata,
   input  logic [31:0]       ext_value,
   output logic              ext_we,
   output logic [31:0]       ext_wdata
);

   localparam int          LANE_W    = $clog2(DATA_W / 8);
   localparam int          TYPE_LSB  = TYPE_MSB - 1;
   localparam logic [1:0]  TYPE1_SEL = 2'b01;

   if (TYPE_MSB < 1 || TYPE_MSB > EXT_W - 1) begin : g_bad_type
      $error("cycle-type field outside the extension register");
   end
   if (CFG_BASE[SPARSE_SHIFT-1:0] != '0) begin : g_bad_base
      $error("configuration base must leave the size field clear");
   end

   cfg_req_t          req_q;
   logic [EXT_W-1:0]  ext_saved_q;
   cfg_status_e       status_q;
   logic [DATA_W-1:0] rdata_q;

   logic              accept, check, ext_set, ext_rst, rd_capture;
   logic              dec_type1;
   cfg_status_e       dec_status;
   logic [DATA_W-1:0] rd_aligned;
   logic [EXT_W-1:0]  ext_type1_val;

   cfg_seq_ctrl u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid),
      .host_done_i  (host_done),
      .status_i     (dec_status),
      .type1_i      (dec_type1),
      .req_ready_o  (req_ready),
      .accept_o     (accept),
      .check_o      (check),
      .host_valid_o (host_valid),
      .ext_set_o    (ext_set),
      .ext_rst_o    (ext_rst),
      .rd_capture_o (rd_capture),
      .rsp_valid_o  (rsp_valid)
   );

   cfg_addr_encode #(
      .ADDR_W       (ADDR_W),
      .CFG_BASE     (CFG_BASE),
      .MAX_T0_DEV   (MAX_T0_DEV),
      .IDSEL_LSB    (IDSEL_LSB),
      .SPARSE_SHIFT (SPARSE_SHIFT)
   ) u_enc (
      .bus_i       (req_q.bus),
      .devfn_i     (req_q.devfn),
      .ofs_i       (req_q.ofs),
      .size_i      (req_q.size),
      .type1_o     (dec_type1),
      .status_o    (dec_status),
      .host_addr_o (host_addr)
   );

   cfg_lane_shift #(
      .DATA_W  (DATA_W),
      .TO_HIGH (1'b1)
   ) u_wr_lane (
      .data_i (req_q.wdata),
      .lane_i (req_q.ofs[LANE_W-1:0]),
      .data_o (host_wdata)
   );

   cfg_lane_shift #(
      .DATA_W  (DATA_W),
      .TO_HIGH (1'b0)
   ) u_rd_lane (
      .data_i (host_rdata),
      .lane_i (req_q.ofs[LANE_W-1:0]),
      .data_o (rd_aligned)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q       <= '0;
         ext_saved_q <= '0;
      end else if (accept) begin
         req_q.bus   <= req_bus;
         req_q.devfn <= req_devfn;
         req_q.ofs   <= req_offset;
         req_q.size  <= req_size;
         req_q.write <= req_write;
         req_q.wdata <= req_wdata;
         ext_saved_q <= ext_value;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     status_q <= CFG_OK;
      else if (check) status_q <= dec_status;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         rdata_q <= '0;
      else if (accept)                    rdata_q <= '0;
      else if (rd_capture && !req_q.write) rdata_q <= rd_aligned;
   end

   always_comb begin
      ext_type1_val = ext_saved_q;
      ext_type1_val[TYPE_MSB:TYPE_LSB] = TYPE1_SEL;
   end

   assign ext_we     = ext_set || ext_rst;
   assign ext_wdata  = ext_set ? ext_type1_val : ext_saved_q;
   assign host_write = req_q.write;
   assign rsp_status = status_q;
   assign rsp_data   = rdata_q;

endmodule

// File: rtl/cfg_addr_checks.sv
module cfg_addr_checks #(
   parameter int ADDR_W = 40
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [1:0]        rsp_status,
   input logic              host_valid,
   input logic [ADDR_W-1:0] host_addr,
   input logic [31:0]       host_wdata,
   input logic              host_done,
   input logic              ext_we,
   input logic [31:0]       ext_wdata
);

   logic       issued_q;
   logic [1:0] ext_cnt_q;
   logic [1:0] last_type_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issued_q    <= 1'b0;
         ext_cnt_q   <= '0;
         last_type_q <= '0;
      end else begin
         if (req_valid && req_ready) begin
            issued_q  <= 1'b0;
            ext_cnt_q <= '0;
         end else begin
            if (host_valid) issued_q <= 1'b1;
            if (ext_we)     ext_cnt_q <= ext_cnt_q + 2'd1;
         end
         if (ext_we) last_type_q <= ext_wdata[31:30];
      end
   end

   p_ready_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   p_hold_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      host_valid && !host_done |=> host_valid && $stable(host_addr) && $stable(host_wdata));

   p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_size_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
      host_valid |-> host_addr[2:0] == 3'b000 && host_addr[4:3] != 2'b10);

   p_no_cycle_on_error_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status != 2'b00 |-> !issued_q);

   p_ext_paired_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ext_cnt_q == 2'd0 || ext_cnt_q == 2'd2);

   p_ext_type_during_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_valid && ext_cnt_q == 2'd1 |-> last_type_q == 2'b01);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !host_valid && !ext_we && !rsp_valid);

endmodule

bind cfg_addr_gen cfg_addr_checks #(.ADDR_W(ADDR_W)) u_cfg_addr_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .rsp_status (rsp_status),
   .host_valid (host_valid),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .host_done  (host_done),
   .ext_we     (ext_we),
   .ext_wdata  (ext_wdata)
);

// File: tb/test_cfg_addr_gen.sv
`timescale 1ns/1ps
module test_cfg_addr_gen;

   localparam int          ADDR_W = 40;
   localparam logic [39:0] BASE   = 40'hC0_0000_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [7:0]        req_bus = '0, req_devfn = '0, req_offset = '0;
   logic [2:0]        req_size = '0;
   logic              req_write = 1'b0;
   logic [31:0]       req_wdata = '0;
   logic              rsp_valid;
   logic [1:0]        rsp_status;
   logic [31:0]       rsp_data;
   logic              host_valid, host_write;
   logic [ADDR_W-1:0] host_addr;
   logic [31:0]       host_wdata;
   logic              host_done = 1'b0;
   logic [31:0]       host_rdata = '0;
   logic [31:0]       ext_reg = '0;
   logic              ext_we;
   logic [31:0]       ext_wdata;

   logic              ext_load = 1'b0;
   logic [31:0]       ext_init = '0;
   int                extw_cnt = 0;
   int                cyc_cnt  = 0;
   int                lat_cnt  = 0;
   logic              prev_hv  = 1'b0;

   logic [39:0]       exp_addr = '0;
   logic [31:0]       exp_wd   = '0;
   logic              exp_wr   = 1'b0;
   logic [31:0]       exp_ext_mid = '0;

   int n_checks = 0, n_fail = 0;
   int mon_checks = 0, mon_fail = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   cfg_addr_gen #(.ADDR_W(ADDR_W), .CFG_BASE(BASE)) i_cfg_addr_gen (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
      .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
      .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_done(host_done), .host_rdata(host_rdata),
      .ext_value(ext_reg), .ext_we(ext_we), .ext_wdata(ext_wdata)
   );

   // extension register model
   always @(posedge clk) begin
      if (ext_load) ext_reg <= ext_init;
      else if (ext_we) begin
         ext_reg  <= ext_wdata;
         extw_cnt <= extw_cnt + 1;
      end
   end

   // host responder: done after a fixed latency
   always @(negedge clk) begin
      if (host_valid && !host_done) begin
         if (lat_cnt == 2) begin
            host_done <= 1'b1;
            lat_cnt   <= 0;
         end else lat_cnt <= lat_cnt + 1;
      end else host_done <= 1'b0;
   end

   // monitor: compares the host cycle against the reference on every clock
   always @(negedge clk) begin
      prev_hv <= host_valid;
      if (host_valid && !prev_hv) cyc_cnt <= cyc_cnt + 1;
      if (rst_n && host_valid) begin
         mon_checks += 1;
         if (host_addr !== exp_addr) begin
            mon_fail += 1;
            $display("FAIL R3/R4/R5 host_addr act=%h exp=%h", host_addr, exp_addr);
         end
         mon_checks += 1;
         if (host_write !== exp_wr || (exp_wr && host_wdata !== exp_wd)) begin
            mon_fail += 1;
            $display("FAIL R6 host write act=%b/%h exp=%b/%h", host_write, host_wdata, exp_wr, exp_wd);
         end
         mon_checks += 1;
         if (ext_reg !== exp_ext_mid) begin
            mon_fail += 1;
            $display("FAIL R8 ext during cycle act=%h exp=%h", ext_reg, exp_ext_mid);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks += 1;
      if (!ok) begin
         n_fail += 1;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic run_req(input logic [7:0] bus, input logic [7:0] devfn, input logic [7:0] off,
                          input logic [2:0] size, input logic wr, input logic [31:0] wd,
                          input logic [31:0] rd, input logic [31:0] ext0);
      logic [4:0]  dev;
      logic [31:0] cfg;
      logic [1:0]  st;
      logic [31:0] exp_rsp;
      logic        t1;
      int          c0, e0;
      dev = devfn[7:3];
      t1  = (bus != 0);
      if (size != 1 && size != 2 && size != 4) st = 2'b10;
      else if (!t1 && dev > 20)                st = 2'b01;
      else                                     st = 2'b00;
      if (!t1) cfg = (32'h1 << (11 + dev)) | ({29'b0, devfn[2:0]} << 8) | {24'b0, off & 8'hFC};
      else     cfg = ({24'b0, bus} << 16) | ({24'b0, devfn} << 8) | {24'b0, off & 8'hFC} | 32'h1;
      exp_addr    = ({8'h0, cfg} << 5) + 40'((size - 3'd1) * 8) + BASE;
      exp_wd      = wd << (off[1:0] * 8);
      exp_wr      = wr;
      exp_ext_mid = t1 ? {2'b01, ext0[29:0]} : ext0;
      exp_rsp     = (st != 2'b00 || wr) ? 32'h0 : (rd >> (off[1:0] * 8));
      host_rdata  = rd;
      @(negedge clk); ext_load = 1'b1; ext_init = ext0;
      @(negedge clk); ext_load = 1'b0;
      c0 = cyc_cnt; e0 = extw_cnt;
      req_bus = bus; req_devfn = devfn; req_offset = off; req_size = size;
      req_write = wr; req_wdata = wd; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R11 ready drops after accept", 64'(req_ready), 64'd0);
      while (!rsp_valid) @(negedge clk);
      chk(rsp_status == st, "R2/R10 status", 64'(rsp_status), 64'(st));
      chk(rsp_data == exp_rsp, "R7 response data", 64'(rsp_data), 64'(exp_rsp));
      chk((cyc_cnt - c0) == ((st == 2'b00) ? 1 : 0), "R2/R10 host cycle count",
          64'(cyc_cnt - c0), 64'((st == 2'b00) ? 1 : 0));
      chk((extw_cnt - e0) == ((st == 2'b00 && t1) ? 2 : 0), "R8/R9 ext write count",
          64'(extw_cnt - e0), 64'((st == 2'b00 && t1) ? 2 : 0));
      chk(ext_reg == ext0, "R9 ext restored", 64'(ext_reg), 64'(ext0));
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R12 response pulse", 64'(rsp_valid), 64'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
      chk(host_valid == 1'b0 && rsp_valid == 1'b0 && ext_we == 1'b0, "R11 reset quiet",
          64'({host_valid, rsp_valid, ext_we}), 64'd0);
      // R1 R3 R5 R7: type 0, device 0, full word
      run_req(8'd0, 8'h00, 8'h00, 3'd4, 1'b0, 32'h0, 32'hDEADBEEF, 32'h0000_0012);
      // R3: highest selectable device, function 7, top register
      run_req(8'd0, 8'hA7, 8'h3C, 3'd4, 1'b0, 32'h0, 32'hCAFEF00D, 32'h1);
      // R2: device 21 and device 31 rejected
      run_req(8'd0, 8'hA8, 8'h00, 3'd4, 1'b0, 32'h0, 32'h5, 32'h7);
      run_req(8'd0, 8'hF8, 8'h10, 3'd2, 1'b1, 32'h1234, 32'h5, 32'h7);
      // R1 R4 R8 R9 R7: type 1 read, halfword at offset 2
      run_req(8'd5, 8'hF8, 8'h0E, 3'd2, 1'b0, 32'h0, 32'h12345678, 32'hC123_4567);
      // R6: byte write at offset 1
      run_req(8'd0, 8'h10, 8'h05, 3'd1, 1'b1, 32'h0000_00AB, 32'h0, 32'h0);
      // R10: bad sizes, including precedence over R2 and a type 1 request
      run_req(8'd0, 8'h08, 8'h00, 3'd3, 1'b0, 32'h0, 32'h9, 32'h3);
      run_req(8'd9, 8'h08, 8'h00, 3'd0, 1'b0, 32'h0, 32'h9, 32'hFFFF_FFFF);
      run_req(8'd0, 8'hA8, 8'h00, 3'd3, 1'b0, 32'h0, 32'h9, 32'h3);
      // R7: byte read at offset 3
      run_req(8'd0, 8'h00, 8'h03, 3'd1, 1'b0, 32'h0, 32'h11223344, 32'h0);
      // R4 R6 R8 R9: type 1 write on the top bus number
      run_req(8'hFF, 8'h5A, 8'h42, 3'd2, 1'b1, 32'h0000_BEEF, 32'h0, 32'h8000_0001);
      repeat (3) @(negedge clk);
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks + mon_checks, n_fail + mon_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         $display("FAIL watchdog act=hung exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks + mon_checks + 1, n_fail + mon_fail + 1);
         $finish;
      end
   end

endmodule